// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter. A request carries a channel number. Numbers 0 to 15 pick an external analog input. Numbers 16, 17 and 18 pick one of three internal references: the low reference, the high reference, or the point halfway between them. Once a request is accepted, the block marks itself busy and drives a one-hot selection for the analog multiplexer. It then runs a short buffered sampling window, followed by a final sampling window whose length is set per request, and then a resolution phase.

During resolution the block presents a trial code to a binary-weighted DAC, one result bit per step, starting from the most significant bit. It reads back one comparator bit, which is high when the sampled input is at or above the DAC level. When the last bit is settled, the block loads a 10-bit result register and raises a done pulse. Every step advances only on cycles where the conversion-clock enable is high. Phase lengths are therefore counted in enable pulses, and the system clock can run faster than the conversion clock. The analog parts (multiplexer, buffer, capacitor array and comparator) sit outside the block.

Top module: `sar_seq`

## Requirements
- R1: While busy, a latched channel number 0..15 drives `ext_sel` one-hot, with bit n meaning input n. While idle, every select bit is low. At most one select bit, across `ext_sel` and `ref_sel`, is ever high.
- R2: Channel 16 sets `ref_sel[0]` (low reference), 17 sets `ref_sel[1]` (high reference) and 18 sets `ref_sel[2]` (midpoint). With ideal references these convert to 0, 1023 and 512. Channels 19..31 select nothing.
- R3: `samp_buf` is high for exactly 2 enabled cycles, starting right after the enabled edge that accepts a request.
- R4: `samp_final` then follows for 2 enabled cycles when `long_samp` was 0 at acceptance, or 8 when it was 1.
- R5: Resolution lasts exactly 10 enabled cycles. The first trial code is 512 (MSB set). Each step keeps the current bit when `cmp` is 1, clears it otherwise, and sets the next lower bit.
- R6: `done` rises on the 14th enabled edge after acceptance with short final sampling, or on the 20th with long final sampling.
- R7: With an ideal comparator, `result` equals the largest code not above the selected input, which is the input itself for integer inputs 0..1023.
- R8: On cycles with `ce` low, nothing advances: phase outputs, `dac_code` and `busy` hold, and a `start` is not accepted.
- R9: `busy` goes high on the accepting edge and low on the edge that raises `done`. A `start` while busy is ignored: the channel, sampling length and result of the running conversion are unchanged.
- R10: `done` stays high for exactly one enabled cycle. `result` changes only on the edge where `done` rises and holds at all other times.
- R11: After reset, `busy`, `done`, `result`, `dac_code` and all select bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Conversion-clock enable; all sequencing steps on it |
| start | input | 1 | Conversion request, taken on an enabled edge when idle |
| chan | input | 5 | Requested channel: 0..15 external, 16 low ref, 17 high ref, 18 midpoint |
| long_samp | input | 1 | 1 selects the 8-cycle final sample, 0 the 2-cycle one |
| cmp | input | 1 | Comparator: 1 when sampled input >= DAC level |
| ext_sel | output | 16 | One-hot external input select |
| ref_sel | output | 3 | One-hot internal reference select (low, high, mid) |
| samp_buf | output | 1 | Buffered sampling window active |
| samp_final | output | 1 | Final sampling window active |
| dac_code | output | 10 | Trial code to the DAC during resolution, 0 otherwise |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion complete, one enabled cycle |
| result | output | 10 | Last conversion result |

## Verification
On every cycle, assertions enforce several invariants. Phase counters stay inside their window lengths. The DAC bit mask stays one-hot while resolving. Select lines are exclusive and fall low whenever the block is idle. The stored channel does not move while busy. `done` and `busy` are never high together, and `result` moves only as `done` rises. Other properties are end-to-end and only the bench scenarios can show them. These are the exact enabled-cycle counts of each phase, the total latency under irregular enable patterns, the converted values for external inputs and the three references, and the dropping of a mid-conversion request with different settings.

// File: rtl/sar_pkg.sv
// Shared definitions for the conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sar_pkg;
    localparam int SAR_BITS = 10;
    localparam int N_EXT    = 16;
    localparam int N_REF    = 3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BUF   = 2'd1,
        PH_FINAL = 2'd2,
        PH_RES   = 2'd3
    } phase_t;
endpackage

// File: rtl/sar_chan_dec.sv
// Channel decoder: turns a latched channel number into one-hot selects
// for the external inputs and the internal references.
// Assumes: chan is stable while en is high; codes past the last reference
// select nothing.
module sar_chan_dec #(
    parameter int N_EXT = 16,
    parameter int N_REF = 3,
    parameter int CHW   = $clog2(N_EXT + N_REF)
) (
    input  logic             en,
    input  logic [CHW-1:0]   chan,
    output logic [N_EXT-1:0] ext_sel,
    output logic [N_REF-1:0] ref_sel
);
    genvar gi;
    generate
        for (gi = 0; gi < N_EXT; gi++) begin : g_ext
            // match one external input code
            assign ext_sel[gi] = en && (chan == CHW'(gi));
        end
        for (gi = 0; gi < N_REF; gi++) begin : g_ref
            // match one internal reference code, placed after the externals
            assign ref_sel[gi] = en && (chan == CHW'(N_EXT + gi));
        end
    endgenerate
endmodule

// File: rtl/sar_phase_ctl.sv
// Phase controller: walks idle -> buffered sample -> final sample ->
// resolution -> idle, counting enabled cycles in each phase.
// Assumes: ce is a one-cycle-wide enable in the clk domain; long_samp is
// captured at acceptance only.
module sar_phase_ctl
    import sar_pkg::*;
#(
    parameter int BUF_LEN   = 2,
    parameter int SHORT_LEN = 2,
    parameter int LONG_LEN  = 8,
    parameter int RES_LEN   = 10
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ce,
    input  logic   start,
    input  logic   long_samp,
    output phase_t phase,
    output logic   accept,
    output logic   res_load,
    output logic   res_step,
    output logic   res_last
);
    localparam int MAXLEN = (LONG_LEN > RES_LEN) ? LONG_LEN : RES_LEN;
    localparam int CW     = $clog2(MAXLEN) + 1;
    localparam logic [CW-1:0] BUF_LAST   = CW'(BUF_LEN - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_LEN - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] RES_LAST   = CW'(RES_LEN - 1);

    logic [CW-1:0] cnt;
    logic          long_q;
    logic [CW-1:0] fin_last;

    // pick the final-sample window end from the captured length choice
    assign fin_last = long_q ? LONG_LAST : SHORT_LAST;

    // strobes for the approximation register and the request handshake
    always_comb begin
        accept   = ce && start && (phase == PH_IDLE);
        res_load = ce && (phase == PH_FINAL) && (cnt == fin_last);
        res_step = ce && (phase == PH_RES);
        res_last = res_step && (cnt == RES_LAST);
    end

    // phase and window counter, advancing only on enabled cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            long_q <= 1'b0;
        end else if (ce) begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase  <= PH_BUF;
                    cnt    <= '0;
                    long_q <= long_samp;
                end
                PH_BUF: begin
                    if (cnt == BUF_LAST) begin
                        phase <= PH_FINAL;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_FINAL: begin
                    if (cnt == fin_last) begin
                        phase <= PH_RES;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_RES: begin
                    if (cnt == RES_LAST) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3
    buf_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BUF) |-> (cnt <= BUF_LAST));
    // R4
    final_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FINAL) |-> (cnt <= (long_q ? LONG_LAST : SHORT_LAST)));
    // R5
    res_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RES) |-> (cnt <= RES_LAST));
    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(phase) && $stable(cnt)));
endmodule

// File: rtl/sar_approx.sv
// Approximation register: holds the DAC trial code, walks a one-hot bit
// mask from MSB to LSB, and stores the final code with a done pulse.
// Assumes: load, step and last are already qualified by the enable.
module sar_approx #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         load,
    input  logic         step,
    input  logic         last,
    input  logic         cmp,
    output logic [W-1:0] trial,
    output logic [W-1:0] result,
    output logic         done
);
    localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mask;
    logic [W-1:0] kept;

    // decide the bit under trial from the comparator
    assign kept = cmp ? trial : (trial & ~mask);

    // trial code, bit mask, result register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial  <= '0;
            mask   <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            if (ce) done <= 1'b0;
            if (load) begin
                trial <= MSB;
                mask  <= MSB;
            end else if (last) begin
                trial  <= '0;
                mask   <= '0;
                result <= kept;
                done   <= 1'b1;
            end else if (step) begin
                trial <= kept | (mask >> 1);
                mask  <= mask >> 1;
            end
        end
    end

    // R5
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ($countones(mask) == 1));
    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ce) |=> done);
    // R10
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ce) |=> !done);
    // R10
    result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> $stable(result));
endmodule

// File: rtl/sar_seq.sv
// Top of the conversion sequencer: latches the request, decodes the
// channel, runs the phase controller and the approximation register.
// Assumes: the comparator output is settled within one clk cycle of a new
// dac_code; all inputs are synchronous to clk.
module sar_seq
    import sar_pkg::*;
#(
    parameter int W     = SAR_BITS,
    parameter int NE    = N_EXT,
    parameter int NR    = N_REF,
    parameter int CHW   = $clog2(NE + NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          start,
    input  logic [CHW-1:0] chan,
    input  logic          long_samp,
    input  logic          cmp,
    output logic [NE-1:0] ext_sel,
    output logic [NR-1:0] ref_sel,
    output logic          samp_buf,
    output logic          samp_final,
    output logic [W-1:0]  dac_code,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  result
);
    phase_t         phase;
    logic           accept, res_load, res_step, res_last;
    logic [CHW-1:0] chan_q;

    // capture the channel only when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n)      chan_q <= '0;
        else if (accept) chan_q <= chan;
    end

    // phase-derived status outputs
    assign busy       = (phase != PH_IDLE);
    assign samp_buf   = (phase == PH_BUF);
    assign samp_final = (phase == PH_FINAL);

    sar_phase_ctl #(
        .BUF_LEN  (2),
        .SHORT_LEN(2),
        .LONG_LEN (8),
        .RES_LEN  (W)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .start    (start),
        .long_samp(long_samp),
        .phase    (phase),
        .accept   (accept),
        .res_load (res_load),
        .res_step (res_step),
        .res_last (res_last)
    );

    sar_chan_dec #(
        .N_EXT(NE),
        .N_REF(NR),
        .CHW  (CHW)
    ) u_dec (
        .en     (busy),
        .chan   (chan_q),
        .ext_sel(ext_sel),
        .ref_sel(ref_sel)
    );

    sar_approx #(
        .W(W)
    ) u_sar (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .load  (res_load),
        .step  (res_step),
        .last  (res_last),
        .cmp   (cmp),
        .trial (dac_code),
        .result(result),
        .done  (done)
    );

    // R1
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_sel, ref_sel}));
    // R1
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({ext_sel, ref_sel} == '0));
    // R9
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R9
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(chan_q));
endmodule

// File: tb/sim_sar_seq.sv
module sim_sar_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0;
    logic       start = 1'b0;
    logic [4:0] chan = '0;
    logic       long_samp = 1'b0;
    logic       cmp;
    logic [15:0] ext_sel;
    logic [2:0]  ref_sel;
    logic        samp_buf, samp_final, busy, done;
    logic [9:0]  dac_code, result;

    int checks = 0;
    int errors = 0;
    int ext_val [16];
    int vin;
    int seed;

    always #10 clk = ~clk;

    sar_seq u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .chan(chan),
        .long_samp(long_samp), .cmp(cmp), .ext_sel(ext_sel), .ref_sel(ref_sel),
        .samp_buf(samp_buf), .samp_final(samp_final), .dac_code(dac_code),
        .busy(busy), .done(done), .result(result)
    );

    // ideal analog model: mux, references and comparator
    always_comb begin
        vin = 0;
        for (int i = 0; i < 16; i++) if (ext_sel[i]) vin = ext_val[i];
        if (ref_sel[0]) vin = 0;
        if (ref_sel[1]) vin = 1023;
        if (ref_sel[2]) vin = 512;
        cmp = (vin >= int'(dac_code));
    end

    function automatic int expect_code(input int ch);
        if (ch < 16)  return ext_val[ch];
        if (ch == 16) return 0;
        if (ch == 17) return 1023;
        if (ch == 18) return 512;
        return 0;
    endfunction

    function automatic int expect_sel(input int ch);
        if (ch < 19) return 1 << ch;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int ch, input bit lng, input int ce_pct, input bit poke);
        int nce = 0, nbuf = 0, nfin = 0, nres = 0, guard = 0;
        int first_trial = -1;
        bit frozen_ok = 1'b1;
        bit pb, pf, pbusy, pres, ce_now;
        logic [9:0] pdac;
        int exp_v = expect_code(ch);
        @(negedge clk);
        chan = 5'(ch); long_samp = lng; start = 1'b1; ce = 1'b1;
        @(negedge clk);
        start = 1'b0; ce = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
        chk(int'({ref_sel, ext_sel}) == expect_sel(ch), "R1/R2 select decode",
            int'({ref_sel, ext_sel}), expect_sel(ch));
        while (!done && guard < 3000) begin
            guard++;
            ce_now = (($urandom % 100) < ce_pct);
            ce = ce_now;
            if (poke && nce == 5) begin
                start = 1'b1; chan = 5'((ch + 3) % 19); long_samp = ~lng;
            end
            pb = samp_buf; pf = samp_final; pbusy = busy; pdac = dac_code;
            pres = busy && (dac_code != 0);
            if (pres && first_trial < 0) first_trial = int'(dac_code);
            @(negedge clk);
            start = 1'b0;
            if (ce_now) begin
                nce++;
                if (pb) nbuf++;
                if (pf) nfin++;
                if (pres) nres++;
            end else if (!done) begin
                if (samp_buf != pb || samp_final != pf || busy != pbusy || dac_code != pdac)
                    frozen_ok = 1'b0;
            end
        end
        chk(guard < 3000, "R6 watchdog per conversion", guard, 0);
        chk(nce == (lng ? 20 : 14), "R6 total enabled cycles", nce, lng ? 20 : 14);
        chk(nbuf == 2, "R3 buffered sample length", nbuf, 2);
        chk(nfin == (lng ? 8 : 2), "R4 final sample length", nfin, lng ? 8 : 2);
        chk(nres == 10, "R5 resolution length", nres, 10);
        chk(first_trial == 512, "R5 first trial code", first_trial, 512);
        chk(int'(result) == exp_v, "R7 conversion result", int'(result), exp_v);
        chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
        chk(frozen_ok, "R8 hold while enable low", int'(frozen_ok), 1);
        ce = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R10 done held without enable", int'(done), 1);
        ce = 1'b1;
        @(negedge clk);
        ce = 1'b0;
        chk(done == 1'b0, "R10 done one enabled cycle", int'(done), 0);
        chk(int'(result) == exp_v, "R10 result held after done", int'(result), exp_v);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed = 7;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) ext_val[i] = int'($urandom % 1024);
        ext_val[0] = 0;
        ext_val[15] = 1023;
        ext_val[5] = 511;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({busy, done} == 2'b00, "R11 busy/done after reset", int'({busy, done}), 0);
        chk(result == '0 && dac_code == '0, "R11 result/dac after reset", int'(result), 0);
        chk({ref_sel, ext_sel} == '0, "R11 selects after reset", int'({ref_sel, ext_sel}), 0);
        // R8 start without enable is not taken
        start = 1'b1; ce = 1'b0; chan = 5'd3;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R8 start ignored with enable low", int'(busy), 0);
        // directed corners
        run_conv(0, 1'b0, 100, 1'b0);
        run_conv(15, 1'b1, 100, 1'b0);
        run_conv(5, 1'b0, 40, 1'b0);
        run_conv(16, 1'b0, 70, 1'b0);
        run_conv(17, 1'b1, 70, 1'b0);
        run_conv(18, 1'b0, 50, 1'b0);
        run_conv(25, 1'b1, 80, 1'b0);
        // R9 start while busy with other settings
        run_conv(7, 1'b0, 100, 1'b1);
        run_conv(2, 1'b1, 60, 1'b1);
        // constrained random
        for (int k = 0; k < 25; k++) begin
            ext_val[k % 16] = int'($urandom % 1024);
            run_conv(int'($urandom % 19), 1'($urandom % 2),
                     30 + int'($urandom % 71), 1'($urandom % 2));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule